// File: doc/BRIEF.md
# Fractional pixel clock divider

This block derives a display pixel clock from a faster source clock. The division ratio is an unsigned fixed-point number with four fraction bits, so the pixel period can be any multiple of 1/16 of a source cycle. A phase accumulator advances by 16 on every source cycle. When it reaches the divider value, the divider is subtracted, and the remainder carries into the next period. Individual periods therefore round to whole source cycles, while their long-run average equals the programmed ratio exactly.

Each output period begins with a rising edge at phase zero. The falling edge sits at a separately programmed position. That field has two fraction bits and is normally set to the divider divided by eight, minus one, which gives roughly half a period. Divider values below 4.0 are raised to 4.0. New divider and falling-edge values take effect only at a period boundary.

An idle-gating bit selects the output mode. When the bit is clear, the clock runs freely. When it is set, a period whose boundary sees no pixel request stays low for its whole length. Each active period also produces a one-cycle strobe for downstream timing logic.

Top module: `fdiv_pixclk`

## Requirements
- R1: While `rst` is high at a clock edge, `pix_clk` and `pix_stb` are 0 after that edge. The period that follows reset release is silent, with both outputs 0 until the first boundary.
- R2: A `cfg_div` value below 0x40 (4.0 source cycles) is treated as 0x40. Both 0x010 and 0x000 therefore give a strobe spacing of 4 source cycles.
- R3: The pixel period averages `cfg_div`/16 source cycles. With 0x040 the strobes are exactly 4 cycles apart. With 0x048 consecutive gaps are 4 or 5 cycles, and any two adjacent gaps add up to 9.
- R4: Every rising edge of `pix_clk` coincides with a `pix_stb` pulse, which marks phase zero of a period.
- R5: `pix_clk` is high while the phase, counted in 1/16 cycles from the period start, is below 4×`cfg_fall`. After reset, with `cfg_div`=0x040 and `cfg_fall`=7, the high time is 2 cycles.
- R6: `cfg_div`, `cfg_fall`, `cfg_idle_en` and `pix_req` are sampled only at the source-clock edge that ends a period. A change made in the middle of a period leaves that period's length and shape unchanged.
- R7: With `cfg_idle_en`=1, a period whose boundary sees `pix_req`=0 keeps `pix_clk` and `pix_stb` at 0 for its whole length.
- R8: With `cfg_idle_en`=0, `pix_req` has no effect and every period is active.
- R9: `pix_stb` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W (12) | Divider, unsigned with 4 fraction bits |
| cfg_fall | input | FALL_W (10) | Falling-edge position with 2 fraction bits (normally divider/8 − 1) |
| cfg_idle_en | input | 1 | 1 = stop the clock for periods with no pixel request; 0 = free-running |
| pix_req | input | 1 | A pixel is waiting to be transferred |
| pix_clk | output | 1 | Registered pixel clock |
| pix_stb | output | 1 | One-cycle strobe at the start of each active period |

## Verification
The integer ratio 0x040 gives a fixed 4-cycle period. It isolates the falling-edge position and separates high time from period length. The fractional ratio 0x048 must produce alternating 4- and 5-cycle gaps that add up to 9, which separates carry of the remainder from plain truncation. Sub-minimum ratios of 0x010 and 0x000 show the clamp at 4 cycles. A divider change made in the middle of a period, followed by gated and free-running phases with `pix_req` low, shows sampling at the boundary and the effect of the idle bit. A stretch of varied ratios, falling-edge positions and request patterns is then compared cycle by cycle against a behavioural model.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // fraction bits of the divider; the accumulator advances by one whole cycle
  localparam int FRAC_BITS = 4;
  localparam int STEP      = 1 << FRAC_BITS;
  // the falling-edge field carries 2 fraction bits fewer than the divider
  localparam int FALL_SHIFT = FRAC_BITS - 2;

  typedef enum logic {
    GATE_FREE = 1'b0,
    GATE_IDLE = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc
  import fdiv_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int MIN_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] phase_nxt,
  output logic             wrap_nxt
);
  localparam logic [DIV_W-1:0] MIN_V  = DIV_W'(MIN_DIV);
  localparam logic [DIV_W:0]   STEP_V = (DIV_W+1)'(STEP);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_clamped;
  logic [DIV_W:0]   sum;
  logic [DIV_W:0]   diff;

  always_comb begin
    div_clamped = (div_in < MIN_V) ? MIN_V : div_in;
    sum         = {1'b0, phase_q} + STEP_V;
    diff        = sum - {1'b0, div_q};
    wrap_nxt    = (sum >= {1'b0, div_q});
    phase_nxt   = wrap_nxt ? diff[DIV_W-1:0] : sum[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      div_q   <= div_clamped;
    end else begin
      phase_q <= phase_nxt;
      if (wrap_nxt) div_q <= div_clamped;
    end
  end

  // R2: the divider in use never drops below the floor
  assert_div_floor_R2: assert property (@(posedge clk) disable iff (rst)
    div_q >= MIN_V);

  // R3: the carried remainder always stays inside the current period
  assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    phase_q < div_q);
endmodule

// File: rtl/fdiv_edge_gen.sv
module fdiv_edge_gen
  import fdiv_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int FALL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  phase_nxt,
  input  logic              wrap_nxt,
  input  logic [FALL_W-1:0] fall_in,
  input  logic              idle_en,
  input  logic              req,
  output logic              pix_clk,
  output logic              pix_stb
);
  localparam int CW = (DIV_W > FALL_W + FALL_SHIFT) ? DIV_W : FALL_W + FALL_SHIFT;

  logic [FALL_W-1:0] fall_q;
  logic [FALL_W-1:0] fall_n;
  logic              act_q;
  logic              act_n;
  logic [CW-1:0]     fall_pos;
  logic [CW-1:0]     phase_ext;
  gate_mode_e        mode;

  always_comb begin
    mode      = idle_en ? GATE_IDLE : GATE_FREE;
    fall_n    = wrap_nxt ? fall_in : fall_q;
    act_n     = wrap_nxt ? ((mode == GATE_FREE) || req) : act_q;
    fall_pos  = CW'({fall_n, {FALL_SHIFT{1'b0}}});
    phase_ext = CW'(phase_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q  <= fall_in;
      act_q   <= 1'b0;
      pix_clk <= 1'b0;
      pix_stb <= 1'b0;
    end else begin
      fall_q  <= fall_n;
      act_q   <= act_n;
      pix_clk <= act_n && (phase_ext < fall_pos);
      pix_stb <= wrap_nxt && act_n;
    end
  end

  // R1: a reset edge leaves both outputs low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pix_clk && !pix_stb));

  // R4: the clock only rises at the start of a period
  assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_clk) |-> pix_stb);

  // R7: an inactive period produces no clock and no strobe
  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (!pix_clk && !pix_stb));

  // R9: the strobe lasts a single cycle
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    pix_stb |=> !pix_stb);
endmodule

// File: rtl/fdiv_pixclk.sv
module fdiv_pixclk
  import fdiv_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int FALL_W  = 10,
  parameter int MIN_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [FALL_W-1:0] cfg_fall,
  input  logic              cfg_idle_en,
  input  logic              pix_req,
  output logic              pix_clk,
  output logic              pix_stb
);
  logic [DIV_W-1:0] phase_nxt;
  logic             wrap_nxt;

  fdiv_phase_acc #(
    .DIV_W  (DIV_W),
    .MIN_DIV(MIN_DIV)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .div_in   (cfg_div),
    .phase_nxt(phase_nxt),
    .wrap_nxt (wrap_nxt)
  );

  fdiv_edge_gen #(
    .DIV_W (DIV_W),
    .FALL_W(FALL_W)
  ) u_edge (
    .clk      (clk),
    .rst      (rst),
    .phase_nxt(phase_nxt),
    .wrap_nxt (wrap_nxt),
    .fall_in  (cfg_fall),
    .idle_en  (cfg_idle_en),
    .req      (pix_req),
    .pix_clk  (pix_clk),
    .pix_stb  (pix_stb)
  );
endmodule

// File: tb/fdiv_pixclk_bench.sv
module fdiv_pixclk_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [11:0] cfg_div = 12'h040;
  logic [9:0]  cfg_fall = 10'd7;
  logic       cfg_idle_en = 1'b0;
  logic       pix_req = 1'b0;
  logic       pix_clk;
  logic       pix_stb;

  fdiv_pixclk u_fdiv_pixclk (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_fall(cfg_fall),
    .cfg_idle_en(cfg_idle_en), .pix_req(pix_req),
    .pix_clk(pix_clk), .pix_stb(pix_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  string tag = "R1";
  bit    started = 0;

  // behavioural reference state
  int m_ph, m_dv, m_fl, m_sum;
  bit m_act, m_wrap, e_clk, e_stb;

  function automatic int clampd(int raw);
    return (raw < 64) ? 64 : raw;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ph = 0; m_dv = clampd(int'(cfg_div)); m_fl = int'(cfg_fall);
      m_act = 0; e_clk = 0; e_stb = 0;
    end else begin
      m_sum  = m_ph + 16;
      m_wrap = (m_sum >= m_dv);
      if (m_wrap) begin
        m_ph  = m_sum - m_dv;
        m_dv  = clampd(int'(cfg_div));
        m_fl  = int'(cfg_fall);
        m_act = !cfg_idle_en || pix_req;
      end else begin
        m_ph = m_sum;
      end
      e_clk = m_act && (m_ph < m_fl * 4);
      e_stb = m_wrap && m_act;
    end
    started = 1;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      check(pix_clk == e_clk, "pix_clk vs model", int'(pix_clk), int'(e_clk));
      check(pix_stb == e_stb, "pix_stb vs model", int'(pix_stb), int'(e_stb));
    end
  end

  task automatic next_stb(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pix_stb && n < 2000);
  endtask

  initial begin
    int n, g1, g2, hi, seen;
    int x;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(!pix_clk && !pix_stb, "outputs in reset", int'(pix_clk) + int'(pix_stb), 0);
    rst = 1'b0;
    // R1: the first period after release is silent
    @(negedge clk);
    check(!pix_clk && !pix_stb, "first period silent", int'(pix_clk) + int'(pix_stb), 0);

    // R5 / R4: high time with divider 4.0 and fall field 7
    tag = "R5";
    next_stb(n);
    tag = "R4";
    check(pix_clk == 1'b1, "clock high on strobe", int'(pix_clk), 1);
    tag = "R5";
    hi = 1;
    @(negedge clk);
    while (pix_clk) begin hi++; @(negedge clk); end
    check(hi == 2, "high width", hi, 2);

    // R3: integer ratio, then fractional ratio
    tag = "R3";
    next_stb(n);
    next_stb(g1);
    check(g1 == 4, "gap at 0x040", g1, 4);
    cfg_div = 12'h048; cfg_fall = 10'd8;
    next_stb(n);
    next_stb(g1);
    next_stb(g2);
    check(g1 + g2 == 9, "two gaps at 0x048", g1 + g2, 9);
    check((g1 == 4 || g1 == 5) && (g2 == 4 || g2 == 5), "gap values at 0x048", g1 * 10 + g2, 45);

    // R2: sub-minimum values clamp to 4.0
    tag = "R2";
    cfg_div = 12'h010; cfg_fall = 10'd1;
    next_stb(n);
    next_stb(n);
    next_stb(g1);
    check(g1 == 4, "gap at 0x010", g1, 4);
    cfg_div = 12'h000;
    next_stb(n);
    next_stb(g1);
    check(g1 == 4, "gap at 0x000", g1, 4);

    // R6: change in mid-period applies only after the boundary
    tag = "R6";
    cfg_div = 12'h040; cfg_fall = 10'd7;
    next_stb(n);
    next_stb(n);
    @(negedge clk);
    cfg_div = 12'h080; cfg_fall = 10'd15;
    next_stb(g1);
    check(g1 == 3, "remaining cycles of old period", g1, 3);
    next_stb(g2);
    check(g2 == 8, "period after boundary", g2, 8);

    // R7: gated mode with no request
    tag = "R7";
    cfg_idle_en = 1'b1; pix_req = 1'b0;
    next_stb(n);
    next_stb(n);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pix_clk || pix_stb) seen++;
    end
    check(seen == 0, "activity while idle", seen, 0);
    pix_req = 1'b1;
    next_stb(n);
    check(n <= 9, "clock resumes on request", n, 9);

    // R8: free-running ignores the request
    tag = "R8";
    cfg_idle_en = 1'b0; pix_req = 1'b0;
    next_stb(n);
    next_stb(g1);
    check(g1 == 8, "free-running gap without request", g1, 8);

    // R9 and R6: varied ratios and requests against the model
    tag = "R9";
    x = 12345;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      pix_req = x[16];
      if (i % 37 == 0) begin
        cfg_div     = 12'(16 + (x % 200));
        cfg_fall    = 10'((int'(cfg_div) / 8) - 1 + (x[20] ? 2 : 0));
        cfg_idle_en = x[18];
      end
    end

    // R1: reset in the middle of operation
    tag = "R1";
    rst = 1'b1;
    @(negedge clk);
    check(!pix_clk && !pix_stb, "outputs after mid-run reset", int'(pix_clk) + int'(pix_stb), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule